// File: doc/BRIEF.md
# Dual-Bank Fixed-Point Multiply-Accumulator

This block multiplies two signed 16-bit operands and folds the 32-bit product into a 40-bit accumulator. Four operations are available: product only, accumulator plus product, accumulator minus product, and clear. A status bit picks how the product lines up with the accumulator. In fractional (1.15) mode the product is sign-extended and moved up one place, so the lowest accumulator bit is zero. In integer (16.0) mode the product is sign-extended into the top 8 bits with no shift. Overflow wraps modulo 2^40, and no saturation is applied.

Every register that software can see exists twice: the X and Y operands, the 40-bit accumulator and the 16-bit feedback word. A second status bit picks which copy is visible. An interrupt handler can flip that bit and work in the spare set in a single cycle, and the suspended task's values stay as they were. The accumulator output is one 40-bit port. It is made of an 8-bit upper part (bits 39..32) and two 16-bit words (bits 31..16 and 15..0).

Top module: `dual_bank_mac`

## Requirements
- R1: After reset, the accumulator and feedback word of both banks read zero, the visible bank is 0 and the mode is fractional.
- R2: With `op_en` high and `op_code` = 2'b00, the next edge loads the accumulator with the aligned signed product of X and Y.
- R3: With `op_code` = 2'b01, the accumulator becomes its old value plus the aligned product, wrapping modulo 2^40.
- R4: With `op_code` = 2'b10, the accumulator becomes its old value minus the aligned product, wrapping modulo 2^40.
- R5: With `op_code` = 2'b11, all 40 accumulator bits become zero, whatever the operands are.
- R6: In fractional mode (`stat_int` = 0) the product is sign-extended, product bit 31 lands on accumulator bit 32, product bit 0 lands on bit 1, and bit 0 is zero.
- R7: In integer mode (`stat_int` = 1) the product lands on bits 31..0 unshifted, and its sign is copied into bits 39..32.
- R8: A pulse on `stat_wr` loads `stat_bank` (0 = primary, 1 = alternate) and `stat_int`. These values govern operations from the next cycle onward, and an operation in the same cycle uses the old ones.
- R9: Register writes and operations change only the visible bank. The hidden bank keeps its contents across any number of switches.
- R10: With `op_to_mf` high, bits 31..16 of the operation result go to the feedback word, and the accumulator is left unchanged.
- R11: With `y_sel_fb` high, the feedback word replaces the Y register as the second multiplier operand.
- R12: `x_wr`, `y_wr` and `mr_wr` load the visible bank's registers. An operation in the same cycle uses the values from before those writes, and an accumulator update from an operation takes priority over `mr_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| stat_wr | input | 1 | Load the mode status bits |
| stat_bank | input | 1 | Bank to make visible (0 primary, 1 alternate) |
| stat_int | input | 1 | 1 = integer mode, 0 = fractional mode |
| x_wr | input | 1 | Write X of the visible bank |
| x_in | input | 16 | X write data |
| y_wr | input | 1 | Write Y of the visible bank |
| y_in | input | 16 | Y write data |
| mr_wr | input | 1 | Write the accumulator of the visible bank |
| mr_in | input | 40 | Accumulator write data |
| op_en | input | 1 | Perform an operation this cycle |
| op_code | input | 2 | 00 multiply, 01 add, 10 subtract, 11 clear |
| op_to_mf | input | 1 | Send result bits 31..16 to the feedback word |
| y_sel_fb | input | 1 | Use the feedback word as the Y operand |
| mr_out | output | 40 | Visible accumulator |
| mf_out | output | 16 | Visible feedback word |
| bank_out | output | 1 | Current visible bank |
| int_mode_out | output | 1 | Current mode bit |

## Verification
The four operations are run against a table that mixes operand signs in both modes. The table includes the most negative value squared, which shows whether fractional alignment and sign extension agree at the top of the range. It also includes a sum that wraps past 2^40 and a difference that crosses zero, which test the modulo behaviour of add and subtract. Directed sequences load different values into each bank and switch back and forth, which separates bank isolation from a shared register. Further cases issue an operation in the same cycle as a register write or a mode write, which shows that the operation reads values from before the edge. The feedback routing and feedback-operand cases produce results that a design ignoring those controls could not match.

// File: rtl/mac_pkg.sv
package mac_pkg;

  localparam int OPW  = 16;
  localparam int PRW  = 2 * OPW;
  localparam int ACCW = PRW + 8;

  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_ADD  = 2'b01,
    OP_SUB  = 2'b10,
    OP_CLR  = 2'b11
  } mac_op_e;

  // Signed OPW x OPW product, full width
  function automatic logic [PRW-1:0] signed_product(input logic [OPW-1:0] a,
                                                    input logic [OPW-1:0] b);
    logic signed [PRW-1:0] sa, sb;
    sa = {{OPW{a[OPW-1]}}, a};
    sb = {{OPW{b[OPW-1]}}, b};
    return sa * sb;
  endfunction

  // Place the product in accumulator coordinates
  function automatic logic [ACCW-1:0] align_product(input logic [PRW-1:0] p,
                                                    input logic int_mode);
    if (int_mode)
      return {{(ACCW-PRW){p[PRW-1]}}, p};
    else
      return {{(ACCW-PRW-1){p[PRW-1]}}, p, 1'b0};
  endfunction

  function automatic logic [ACCW-1:0] combine(input mac_op_e op,
                                              input logic [ACCW-1:0] acc,
                                              input logic [ACCW-1:0] term);
    case (op)
      OP_MUL:  return term;
      OP_ADD:  return acc + term;
      OP_SUB:  return acc - term;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/mac_bank_regs.sv
module mac_bank_regs
  import mac_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x_we,
  input  logic [OPW-1:0]  x_d,
  input  logic            y_we,
  input  logic [OPW-1:0]  y_d,
  input  logic            mr_we,
  input  logic [ACCW-1:0] mr_d,
  input  logic            mf_we,
  input  logic [OPW-1:0]  mf_d,
  output logic [OPW-1:0]  x_q,
  output logic [OPW-1:0]  y_q,
  output logic [ACCW-1:0] mr_q,
  output logic [OPW-1:0]  mf_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q  <= '0;
      y_q  <= '0;
      mr_q <= '0;
      mf_q <= '0;
    end else begin
      if (x_we)  x_q  <= x_d;
      if (y_we)  y_q  <= y_d;
      if (mr_we) mr_q <= mr_d;
      if (mf_we) mf_q <= mf_d;
    end
  end

endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
  import mac_pkg::*;
(
  input  logic [OPW-1:0]  x_op,
  input  logic [OPW-1:0]  y_op,
  input  logic [ACCW-1:0] acc,
  input  mac_op_e         op,
  input  logic            int_mode,
  output logic [PRW-1:0]  product,
  output logic [ACCW-1:0] result
);

  logic [ACCW-1:0] aligned;

  always_comb begin
    product = signed_product(x_op, y_op);
    aligned = align_product(product, int_mode);
    result  = combine(op, acc, aligned);
  end

endmodule

// File: rtl/dual_bank_mac.sv
module dual_bank_mac
  import mac_pkg::*;
#(
  parameter int BANKS = 2,
  localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stat_wr,
  input  logic [BW-1:0]   stat_bank,
  input  logic            stat_int,
  input  logic            x_wr,
  input  logic [OPW-1:0]  x_in,
  input  logic            y_wr,
  input  logic [OPW-1:0]  y_in,
  input  logic            mr_wr,
  input  logic [ACCW-1:0] mr_in,
  input  logic            op_en,
  input  logic [1:0]      op_code,
  input  logic            op_to_mf,
  input  logic            y_sel_fb,
  output logic [ACCW-1:0] mr_out,
  output logic [OPW-1:0]  mf_out,
  output logic [BW-1:0]   bank_out,
  output logic            int_mode_out
);

  logic [BW-1:0] bank_q;
  logic          int_q;

  // Mode status register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      int_q  <= 1'b0;
    end else if (stat_wr) begin
      bank_q <= stat_bank;
      int_q  <= stat_int;
    end
  end

  logic [OPW-1:0]  x_q  [BANKS];
  logic [OPW-1:0]  y_q  [BANKS];
  logic [ACCW-1:0] mr_q [BANKS];
  logic [OPW-1:0]  mf_q [BANKS];

  // Named internal events
  logic            evt_op_to_mr;
  logic            evt_op_to_mf;
  logic            evt_mr_load;
  logic            evt_mr_change;
  mac_op_e         op_sel;
  logic [OPW-1:0]  x_act, y_act, mf_act, y_operand;
  logic [ACCW-1:0] mr_act, mr_next, dp_result;
  logic [PRW-1:0]  dp_product;

  assign op_sel        = mac_op_e'(op_code);
  assign evt_op_to_mr  = op_en && !op_to_mf;
  assign evt_op_to_mf  = op_en && op_to_mf;
  assign evt_mr_load   = mr_wr && !evt_op_to_mr;
  assign evt_mr_change = evt_op_to_mr || mr_wr;
  assign mr_next       = evt_op_to_mr ? dp_result : mr_in;

  assign x_act  = x_q[bank_q];
  assign y_act  = y_q[bank_q];
  assign mr_act = mr_q[bank_q];
  assign mf_act = mf_q[bank_q];
  assign y_operand = y_sel_fb ? mf_act : y_act;

  generate
    for (genvar g = 0; g < BANKS; g++) begin : g_bank
      logic sel;
      assign sel = (bank_q == BW'(g));
      mac_bank_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .x_we  (sel && x_wr),
        .x_d   (x_in),
        .y_we  (sel && y_wr),
        .y_d   (y_in),
        .mr_we (sel && evt_mr_change),
        .mr_d  (mr_next),
        .mf_we (sel && evt_op_to_mf),
        .mf_d  (dp_result[PRW-1:OPW]),
        .x_q   (x_q[g]),
        .y_q   (y_q[g]),
        .mr_q  (mr_q[g]),
        .mf_q  (mf_q[g])
      );
    end
  endgenerate

  mac_datapath u_dp (
    .x_op     (x_act),
    .y_op     (y_operand),
    .acc      (mr_act),
    .op       (op_sel),
    .int_mode (int_q),
    .product  (dp_product),
    .result   (dp_result)
  );

  assign mr_out       = mr_act;
  assign mf_out       = mf_act;
  assign bank_out     = bank_q;
  assign int_mode_out = int_q;

  // R5
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_op_to_mr && op_sel == OP_CLR && !stat_wr) |=> (mr_out == '0));

  // R6
  frac_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_op_to_mr && op_sel == OP_MUL && !int_q && !stat_wr) |=> (mr_out[0] == 1'b0));

  // R7
  int_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_op_to_mr && op_sel == OP_MUL && int_q && !stat_wr)
      |=> ($countones(mr_out[ACCW-1:PRW-1]) == 0 ||
           $countones(mr_out[ACCW-1:PRW-1]) == ACCW - PRW + 1));

  // R8
  stat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (bank_out == $past(stat_bank) && int_mode_out == $past(stat_int)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_mr_change && !stat_wr) |=> $stable(mr_out));

  // R10
  mf_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_op_to_mf && !mr_wr && !stat_wr) |=> ($stable(mr_out) && mf_out == $past(dp_result[PRW-1:OPW])));

  // R12
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_mr_load && !stat_wr) |=> (mr_out == $past(mr_in)));

endmodule

// File: tb/dual_bank_mac_bench.sv
module dual_bank_mac_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stat_wr = 0, stat_bank = 0, stat_int = 0;
  logic        x_wr = 0, y_wr = 0, mr_wr = 0;
  logic [15:0] x_in = 0, y_in = 0;
  logic [39:0] mr_in = 0;
  logic        op_en = 0, op_to_mf = 0, y_sel_fb = 0;
  logic [1:0]  op_code = 0;
  logic [39:0] mr_out;
  logic [15:0] mf_out;
  logic        bank_out, int_mode_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_bank_mac u_dual_bank_mac (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .stat_bank(stat_bank),
    .stat_int(stat_int), .x_wr(x_wr), .x_in(x_in), .y_wr(y_wr), .y_in(y_in),
    .mr_wr(mr_wr), .mr_in(mr_in), .op_en(op_en), .op_code(op_code),
    .op_to_mf(op_to_mf), .y_sel_fb(y_sel_fb), .mr_out(mr_out), .mf_out(mf_out),
    .bank_out(bank_out), .int_mode_out(int_mode_out)
  );

  typedef struct packed {
    logic        im;
    logic [1:0]  op;
    logic [15:0] x;
    logic [15:0] y;
    logic [39:0] acc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b00, 16'h4000, 16'h4000, 40'h0},
    '{1'b0, 2'b00, 16'h8000, 16'h8000, 40'h0},
    '{1'b0, 2'b00, 16'h8000, 16'h7FFF, 40'h12_3456_7890},
    '{1'b1, 2'b00, 16'hFFFD, 16'h0007, 40'h0},
    '{1'b1, 2'b01, 16'h0001, 16'h0001, 40'h7F_FFFF_FFFF},
    '{1'b1, 2'b01, 16'h0001, 16'h0001, 40'hFF_FFFF_FFFF},
    '{1'b0, 2'b01, 16'hC000, 16'h3000, 40'h00_1000_0000},
    '{1'b1, 2'b10, 16'h0005, 16'h0003, 40'h00_0000_0002},
    '{1'b0, 2'b10, 16'hFFFF, 16'h0002, 40'h80_0000_0000},
    '{1'b0, 2'b11, 16'h7FFF, 16'h7FFF, 40'h55_AAAA_5555}
  };

  // Reference model: wide signed arithmetic, doubling for fractional mode
  function automatic logic [39:0] ref_mac(logic im, logic [1:0] op,
                                          logic [15:0] x, logic [15:0] y,
                                          logic [39:0] acc);
    longint p;
    p = longint'($signed(x)) * longint'($signed(y));
    if (!im) p = p * 2;
    case (op)
      2'b00:   return p[39:0];
      2'b01:   return 40'(acc + p[39:0]);
      2'b10:   return 40'(acc - p[39:0]);
      default: return 40'h0;
    endcase
  endfunction

  task automatic check(string req, logic [39:0] act, logic [39:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    stat_wr = 0; x_wr = 0; y_wr = 0; mr_wr = 0;
    op_en = 0; op_to_mf = 0; y_sel_fb = 0;
  endtask

  task automatic set_stat(logic b, logic im);
    @(negedge clk);
    stat_wr = 1; stat_bank = b; stat_int = im;
    @(negedge clk);
    idle();
  endtask

  task automatic load_regs(logic [15:0] x, logic [15:0] y, logic [39:0] acc);
    @(negedge clk);
    x_wr = 1; x_in = x; y_wr = 1; y_in = y; mr_wr = 1; mr_in = acc;
    @(negedge clk);
    idle();
  endtask

  task automatic do_op(logic [1:0] op, logic to_mf, logic fb);
    @(negedge clk);
    op_en = 1; op_code = op; op_to_mf = to_mf; y_sel_fb = fb;
    @(negedge clk);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 mr", mr_out, 40'h0);
    check("R1 mf", {24'h0, mf_out}, 40'h0);
    check("R1 bank/mode", {38'h0, bank_out, int_mode_out}, 40'h0);
    set_stat(1, 0);
    check("R1 alt bank mr", mr_out, 40'h0);
    set_stat(0, 0);

    // Vector table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      set_stat(0, VECS[i].im);
      load_regs(VECS[i].x, VECS[i].y, VECS[i].acc);
      do_op(VECS[i].op, 0, 0);
      check($sformatf("R2-7 vec%0d", i), mr_out,
            ref_mac(VECS[i].im, VECS[i].op, VECS[i].x, VECS[i].y, VECS[i].acc));
    end

    // R9 bank isolation
    set_stat(0, 1);
    load_regs(16'h0003, 16'h0004, 40'h11_0000_0001);
    set_stat(1, 1);
    check("R9 alt untouched", mr_out, 40'h0);
    load_regs(16'h0010, 16'h0010, 40'h22_0000_0000);
    do_op(2'b01, 0, 0);
    check("R9 alt op", mr_out, 40'h22_0000_0100);
    set_stat(0, 1);
    check("R9 primary kept", mr_out, 40'h11_0000_0001);
    do_op(2'b00, 0, 0);
    check("R9 primary operands kept", mr_out, 40'h00_0000_000C);
    set_stat(1, 1);
    check("R9 alt kept", mr_out, 40'h22_0000_0100);

    // R10 feedback routing, then R11 feedback operand
    set_stat(0, 0);
    load_regs(16'h4000, 16'h4000, 40'h00_0000_1234);
    do_op(2'b01, 1, 0);
    check("R10 mf", {24'h0, mf_out}, 40'h2000);
    check("R10 mr unchanged", mr_out, 40'h00_0000_1234);
    set_stat(0, 1);
    load_regs(16'h0003, 16'h0001, 40'h0);
    do_op(2'b00, 0, 1);
    check("R11 fb operand", mr_out, ref_mac(1, 2'b00, 16'h0003, 16'h2000, 40'h0));

    // R12 same-cycle write and operation
    load_regs(16'h0002, 16'h0005, 40'h0);
    @(negedge clk);
    op_en = 1; op_code = 2'b00; x_wr = 1; x_in = 16'h0100;
    mr_wr = 1; mr_in = 40'hAB_CDEF_0123;
    @(negedge clk);
    idle();
    check("R12 old x, op wins", mr_out, 40'h00_0000_000A);
    do_op(2'b00, 0, 0);
    check("R12 new x", mr_out, 40'h00_0000_0500);

    // R8 mode write in same cycle as operation uses old mode
    @(negedge clk);
    op_en = 1; op_code = 2'b00; stat_wr = 1; stat_bank = 0; stat_int = 0;
    @(negedge clk);
    idle();
    check("R8 old mode", mr_out, 40'h00_0000_0500);
    do_op(2'b00, 0, 0);
    check("R8 new mode", mr_out, 40'h00_0000_0A00);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule